// File: doc/BRIEF.md
# Pulse-position command frame decoder

This block turns a stream of recovered line bits from a reader into command bytes. Each line bit arrives with a one-cycle valid strobe. The block keeps an 8-bit history of the most recent bits and waits, while idle, for the start-of-frame pattern. Once a frame has started, it evaluates every group of eight line bits as one symbol.

A symbol is one of four 2-bit data values, the end-of-frame marker, or an illegal pattern. Four data symbols make one byte. The first symbol lands in the least significant bit pair, and the byte is presented on an output port with a one-cycle strobe. A good end of frame pulses a done output. An illegal symbol pulses an error output. Both return the block to idle. Bytes beyond a per-frame limit are not emitted; each one is flagged instead.

Every output is a registered one-cycle pulse. It appears in the cycle after the clock edge that took the line bit completing the symbol.

Top module: `ppm_cmd_decoder`

## Requirements
- R1: After reset all output strobes are low, the block is idle, and the bit history holds all ones. Seven line bits 1111011 sent straight after reset therefore do not complete a start pattern.
- R2: While idle, a frame begins on the valid bit that makes the history, with the newest bit at bit 0, equal 8'h7B.
- R3: Inside a frame, the eight line bits since the last evaluation form a symbol, with the first bit at bit 7. Patterns 8'hBF, 8'hEF, 8'hFB and 8'hFE carry the values 0, 1, 2 and 3.
- R4: Symbol 8'hDF ends the frame. frame_done_o pulses for one cycle, the block returns to idle, and data symbols not yet completing a byte are discarded.
- R5: Any other symbol pulses error_o for one cycle and returns the block to idle, with no frame_done_o and no byte for the partial data.
- R6: Each data symbol shifts the byte accumulator right by two and inserts its value at bits 7:6. On every fourth data symbol the assembled byte appears on byte_o with byte_valid_o high for one cycle.
- R7: The history is reloaded with all ones after every evaluated symbol, so zeros from that symbol cannot help form a later start pattern.
- R8: All output strobes are mutually exclusive, and each lasts exactly one cycle.
- R9: At most MAX_BYTES (default 32) bytes are emitted per frame. Each byte completed after that is dropped and overflow_o pulses instead. A following end symbol still raises frame_done_o.
- R10: While bit_valid_i is low, bit_i is ignored and no state changes. No output strobe rises in the next cycle.
- R11: A new start pattern clears the byte count, pair count and accumulator, so a frame that follows an overflowed frame emits bytes normally.
- R12: The start pattern 8'h7B seen as a symbol inside a frame is illegal and raises error_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Recovered line bit |
| bit_valid_i | input | 1 | bit_i is valid this cycle |
| byte_o | output | 8 | Assembled command byte |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |
| frame_done_o | output | 1 | One-cycle pulse on a good end of frame |
| error_o | output | 1 | One-cycle pulse on an illegal symbol |
| overflow_o | output | 1 | One-cycle pulse for a byte dropped past the length cap |

## Verification
The bench targets the following corner cases, and the failure each one would expose:
- A frame ending on an odd number of data symbols. A design that flushed partial data would emit a spurious byte.
- An error symbol ending in a zero, followed by seven bits that would complete a start pattern only if the history were not reloaded. A design without the reload would start a phantom frame and emit bytes.
- The same seven bits straight after reset. These catch a history preset to zero.
- A frame of one byte more than the cap. A design with a wrapping or missing count would emit a 33rd byte or lose the done pulse.
- Frames that follow errors and overflows, including an empty frame. These show whether the count and pairing were cleared on each start.
- A run of toggling bit_i with the valid strobe low inside a frame. A design that sampled unqualified bits would corrupt the byte in progress.

// File: rtl/ppm_dec_pkg.sv
package ppm_dec_pkg;
  localparam int unsigned SYM_W    = 8;
  localparam int unsigned PAIR_W   = 2;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned NUM_VALS = 1 << PAIR_W;
  localparam int unsigned PAIRS    = BYTE_W / PAIR_W;

  localparam logic [SYM_W-1:0] PAT_SOF = 8'h7B;
  localparam logic [SYM_W-1:0] PAT_EOF = 8'hDF;

  typedef enum logic [1:0] {SYM_DATA, SYM_EOF, SYM_BAD} sym_kind_e;
  typedef enum logic {ST_IDLE, ST_FRAME} frame_st_e;

  // data value k: single low bit at position 6-2k
  function automatic logic [SYM_W-1:0] data_pat(input int unsigned k);
    logic [SYM_W-1:0] m;
    m = 8'h40 >> (2 * k);
    return ~m;
  endfunction
endpackage

// File: rtl/ppm_hist_reg.sv
module ppm_hist_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic         reload_i,
  output logic [W-1:0] hist_next_o
);
  logic [W-1:0] hist_q;

  assign hist_next_o = {hist_q[W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '1;
    else if (shift_i) hist_q <= reload_i ? '1 : hist_next_o;
  end

  a_r7_reload_with_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |-> shift_i);
  a_r7_ones_after_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && reload_i) |=> (hist_q == '1));
  a_r10_hold_without_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_q));
endmodule

// File: rtl/ppm_sym_dec.sv
module ppm_sym_dec
  import ppm_dec_pkg::*;
(
  input  logic [SYM_W-1:0]  pat_i,
  output sym_kind_e         kind_o,
  output logic [PAIR_W-1:0] val_o
);
  logic [NUM_VALS-1:0] hit;

  for (genvar k = 0; k < NUM_VALS; k++) begin : g_pat
    assign hit[k] = (pat_i == data_pat(k));
  end

  always_comb begin
    val_o = '0;
    for (int k = 0; k < NUM_VALS; k++) begin
      if (hit[k]) val_o = PAIR_W'(k);
    end
    if (|hit)                kind_o = SYM_DATA;
    else if (pat_i == PAT_EOF) kind_o = SYM_EOF;
    else                     kind_o = SYM_BAD;
  end

  always_comb begin
    a_r3_hits_onehot: assert ($onehot0(hit));
  end
endmodule

// File: rtl/ppm_byte_asm.sv
module ppm_byte_asm
  import ppm_dec_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 32,
  localparam int unsigned LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int unsigned CNT_W    = $clog2(PAIRS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sym_en_i,
  input  logic [PAIR_W-1:0] val_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              overflow_o
);
  logic [BYTE_W-1:0] acc_q, acc_next;
  logic [CNT_W-1:0]  pair_q;
  logic [LEN_W-1:0]  len_q;
  logic              at_cap;

  assign acc_next = {val_i, acc_q[BYTE_W-1:PAIR_W]};
  assign at_cap   = (len_q >= LEN_W'(MAX_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= '0;
      pair_q       <= '0;
      len_q        <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      overflow_o   <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      overflow_o   <= 1'b0;
      if (start_i) begin
        acc_q  <= '0;
        pair_q <= '0;
        len_q  <= '0;
      end else if (sym_en_i) begin
        acc_q <= acc_next;
        if (pair_q == CNT_W'(PAIRS - 1)) begin
          pair_q <= '0;
          if (!at_cap) begin
            byte_o       <= acc_next;
            byte_valid_o <= 1'b1;
            len_q        <= len_q + 1'b1;
          end else begin
            overflow_o <= 1'b1;
          end
        end else begin
          pair_q <= pair_q + 1'b1;
        end
      end
    end
  end

  a_r9_len_capped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LEN_W'(MAX_BYTES));
  a_r9_ovf_only_at_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> (len_q == LEN_W'(MAX_BYTES)));
  a_r11_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (len_q == '0 && pair_q == '0));
  a_r6_byte_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);
endmodule

// File: rtl/ppm_cmd_decoder.sv
module ppm_cmd_decoder
  import ppm_dec_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              frame_done_o,
  output logic              error_o,
  output logic              overflow_o
);
  localparam int unsigned SLOT_W = $clog2(SYM_W);

  frame_st_e         state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SYM_W-1:0]  hist_next;
  sym_kind_e         kind;
  logic [PAIR_W-1:0] val;
  logic              start, eval, sym_en;

  assign start  = (state_q == ST_IDLE) && bit_valid_i && (hist_next == PAT_SOF);
  assign eval   = (state_q == ST_FRAME) && bit_valid_i && (slot_q == SLOT_W'(SYM_W - 1));
  assign sym_en = eval && (kind == SYM_DATA);

  ppm_hist_reg #(.W(SYM_W)) u_hist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_i     (bit_valid_i),
    .bit_i       (bit_i),
    .reload_i    (eval),
    .hist_next_o (hist_next)
  );

  ppm_sym_dec u_dec (
    .pat_i  (hist_next),
    .kind_o (kind),
    .val_o  (val)
  );

  ppm_byte_asm #(.MAX_BYTES(MAX_BYTES)) u_asm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .sym_en_i     (sym_en),
    .val_i        (val),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .overflow_o   (overflow_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      slot_q       <= '0;
      frame_done_o <= 1'b0;
      error_o      <= 1'b0;
    end else begin
      frame_done_o <= 1'b0;
      error_o      <= 1'b0;
      if (start) begin
        state_q <= ST_FRAME;
        slot_q  <= '0;
      end else if (state_q == ST_FRAME && bit_valid_i) begin
        slot_q <= slot_q + 1'b1;
        if (eval && kind != SYM_DATA) begin
          state_q      <= ST_IDLE;
          frame_done_o <= (kind == SYM_EOF);
          error_o      <= (kind == SYM_BAD);
        end
      end
    end
  end

  a_r8_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_o, frame_done_o, error_o, overflow_o}));
  a_r10_quiet_without_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> !(byte_valid_o || frame_done_o || error_o || overflow_o));
  a_r4_done_leaves_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (state_q == ST_IDLE));
  a_r5_error_leaves_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (state_q == ST_IDLE));
  a_r8_done_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  a_r2_start_enters_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state_q == ST_FRAME && slot_q == '0));
endmodule

// File: tb/ppm_cmd_decoder_tb_top.sv
module ppm_cmd_decoder_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       bit_i;
  logic       bit_valid_i;
  logic [7:0] byte_o;
  logic       byte_valid_o, frame_done_o, error_o, overflow_o;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  localparam logic [1:0] K_BYTE = 2'd0, K_DONE = 2'd1, K_ERR = 2'd2, K_OVF = 2'd3;

  always #10 clk_i = ~clk_i;

  ppm_cmd_decoder dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_i        (bit_i),
    .bit_valid_i  (bit_valid_i),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .frame_done_o (frame_done_o),
    .error_o      (error_o),
    .overflow_o   (overflow_o)
  );

  function automatic logic [7:0] dpat(input logic [1:0] v);
    logic [7:0] m;
    m = 8'h40 >> (2 * int'(v));
    return ~m;
  endfunction

  task automatic push(input logic [1:0] k, input logic [7:0] d, input string tag);
    exp_q.push_back({k, d});
    tag_q.push_back(tag);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    bit_i       = b;
    bit_valid_i = 1'b1;
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    bit_i       = ~b;  // noise while invalid (R10)
  endtask

  task automatic send_pat(input logic [7:0] p);
    for (int i = 7; i >= 0; i--) send_bit(p[i]);
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int k = 0; k < 4; k++) send_pat(dpat(d[2*k +: 2]));
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    logic [9:0] got;
    logic [9:0] exp;
    string      tag;
    if (rst_ni && (byte_valid_o || frame_done_o || error_o || overflow_o)) begin
      checks++;
      if (byte_valid_o)      got = {K_BYTE, byte_o};
      else if (frame_done_o) got = {K_DONE, 8'h00};
      else if (error_o)      got = {K_ERR, 8'h00};
      else                   got = {K_OVF, 8'h00};
      if ($countones({byte_valid_o, frame_done_o, error_o, overflow_o}) > 1) begin
        errors++;
        $display("FAIL R8 several strobes at once: actual %b expected one",
                 {byte_valid_o, frame_done_o, error_o, overflow_o});
      end else if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected event: actual %h expected none", got);
      end else begin
        exp = exp_q.pop_front();
        tag = tag_q.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL %s event mismatch: actual %h expected %h", tag, got, exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni      = 1'b0;
    bit_i       = 1'b0;
    bit_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R1 reset state
    checks++;
    if ({byte_valid_o, frame_done_o, error_o, overflow_o} !== 4'b0) begin
      errors++;
      $display("FAIL R1 strobes after reset: actual %b expected 0000",
               {byte_valid_o, frame_done_o, error_o, overflow_o});
    end

    // R1: history preset to ones, seven bits must not start a frame
    for (int i = 6; i >= 0; i--) send_bit(logic'((7'b1111011 >> i) & 7'd1));
    send_byte(8'h00);

    // R2 R3 R6 R4: two bytes then end
    send_pat(8'h7B);
    push(K_BYTE, 8'hA5, "R3"); send_byte(8'hA5);
    push(K_BYTE, 8'h3C, "R6"); send_byte(8'h3C);
    push(K_DONE, 8'h00, "R4"); send_pat(8'hDF);

    // R4: partial symbols discarded at end
    send_pat(8'h7B);
    push(K_BYTE, 8'h5A, "R3"); send_byte(8'h5A);
    send_pat(dpat(2'd1)); send_pat(dpat(2'd2));
    push(K_DONE, 8'h00, "R4"); send_pat(8'hDF);

    // R12 R5: start pattern inside frame is illegal
    send_pat(8'h7B);
    push(K_BYTE, 8'hC3, "R6"); send_byte(8'hC3);
    push(K_ERR, 8'h00, "R12"); send_pat(8'h7B);

    // R5: all-ones symbol is illegal
    send_pat(8'h7B);
    push(K_BYTE, 8'h81, "R3"); send_byte(8'h81);
    send_pat(dpat(2'd3));
    push(K_ERR, 8'h00, "R5"); send_pat(8'hFF);

    // R7: error symbol ending in zero, then seven start bits must not start
    send_pat(8'h7B);
    send_pat(dpat(2'd0)); send_pat(dpat(2'd3));
    push(K_ERR, 8'h00, "R7"); send_pat(8'h00);
    for (int i = 6; i >= 0; i--) send_bit(logic'((7'b1111011 >> i) & 7'd1));
    send_byte(8'h00);

    // R4: empty frame
    send_pat(8'h7B);
    push(K_DONE, 8'h00, "R4"); send_pat(8'hDF);

    // R10: invalid cycles with toggling bit inside a frame
    send_pat(8'h7B);
    send_pat(dpat(2'd2));
    for (int i = 0; i < 24; i++) begin
      @(negedge clk_i);
      bit_i = logic'(i & 1);
    end
    send_pat(dpat(2'd0)); send_pat(dpat(2'd3)); send_pat(dpat(2'd1));
    push(K_BYTE, 8'h72, "R10");
    push(K_DONE, 8'h00, "R10"); send_pat(8'hDF);

    // R9: one byte past the cap
    send_pat(8'h7B);
    for (int n = 0; n < 33; n++) begin
      if (n < 32) push(K_BYTE, 8'(n * 7 + 1), "R9");
      else        push(K_OVF, 8'h00, "R9");
      send_byte(8'(n * 7 + 1));
    end
    push(K_DONE, 8'h00, "R9"); send_pat(8'hDF);

    // R11: next frame restarts counting
    send_pat(8'h7B);
    push(K_BYTE, 8'hE7, "R11"); send_byte(8'hE7);
    push(K_DONE, 8'h00, "R11"); send_pat(8'hDF);

    repeat (10) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing events: actual %0d pending expected 0",
               tag_q[0], exp_q.size());
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule